// File: doc/BRIEF.md
# Comparison Divider and Phase Detector with Lock Flag

This block sits in the digital half of a frequency synthesiser. Reference ticks arrive as single-cycle strobes in the system clock domain. A power-of-two divider reduces them to a comparison pulse. The divide ratio is picked by a three-bit code. A phase-frequency detector races the comparison pulse against feedback strobes from the main divider. It raises up and down pump requests that an external charge pump turns into loop current.

A lock monitor watches how long the pump requests stay high. When requests stay narrow for a run of comparison periods, it releases its flag. The flag is open-drain in style: released (output enable low) means in lock, and actively pulled low means out of lock. Three further controls act on the outputs. A pump-disable pin sets the pump outputs to high impedance. A drive-off control turns off the varactor drive enable. A test control routes the feedback rate divided by two and the comparison pulse onto two general port outputs, which otherwise show programmed data.

Top module: `pll_phase_ctrl`

## Requirements
- R1: Code k on `ratio_sel` (0..7) selects a divide ratio N = 2^(k+1). With `ref_tick` held high after reset, the comparison pulse is a single cycle that appears after the N-th tick and then every N ticks.
- R2: If the ratio code is lowered while the divider count is already at or above the new limit, the next reference tick wraps the divider and emits a comparison pulse.
- R3: A comparison pulse sets `up_req` on the following cycle, and a `fb_tick` sets `dn_req` on the following cycle. When both requests are high in a cycle, both are low in the next cycle.
- R4: While `pump_disable` is 1, `up_oe` and `dn_oe` are 0 and the request values themselves are unchanged. While it is 0, both enables are 1.
- R5: `drive_en` is the inverse of `drive_off`.
- R6: `lock_out` is always 0. `lock_oe` is 1 (flag pulled low, unlocked) until 16 comparison pulses have occurred with no over-width request. It goes to 0 in the cycle after the 16th such pulse.
- R7: If `up_req` or `dn_req` is high for 3 consecutive cycles, `lock_oe` is 1 in the next cycle and the lock count restarts from zero.
- R8: With `test_mode` = 1, `port_out[0]` toggles on every `fb_tick` (starting at 0 after reset) and `port_out[1]` is the comparison pulse. With `test_mode` = 0, `port_out` equals `port_data`.
- R9: After reset, `up_req` and `dn_req` are 0, `lock_oe` is 1 and the divider count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference strobe, one cycle per reference edge |
| fb_tick | input | 1 | Feedback strobe from the main divider |
| ratio_sel | input | 3 | Reference divide ratio code |
| pump_disable | input | 1 | Forces the pump outputs to high impedance |
| drive_off | input | 1 | Turns off the varactor drive |
| test_mode | input | 1 | Routes internal signals onto the ports |
| port_data | input | 2 | Programmed port values |
| up_req | output | 1 | Pump up request |
| dn_req | output | 1 | Pump down request |
| up_oe | output | 1 | Output enable for the up request |
| dn_oe | output | 1 | Output enable for the down request |
| drive_en | output | 1 | Varactor drive enable |
| lock_out | output | 1 | Lock pin value (always low) |
| lock_oe | output | 1 | Lock pin enable; 0 means in lock |
| port_out | output | 2 | Port pins |

## Verification
On every cycle, the assertions check the detector rules: an edge sets its request and a coincident pair clears. They also check that comparison pulses last one cycle, that the feedback toggle follows each feedback strobe, and that a three-cycle request always drops lock. Other behaviours can only be shown by the bench's scenarios. These are the exact divide ratio for each of the eight codes, the wrap on a ratio change, and the lock counting up to the sixteenth clean period. The same holds for the effect of the pump-disable, drive-off and test controls on the pins.

// File: rtl/pll_phase_pkg.sv
package pll_phase_pkg;
  localparam int SEL_W       = 3;
  localparam int LOCK_CYCLES = 16;
  localparam int MAX_WIDTH   = 2;
  localparam int PORT_W      = 2;
  typedef logic [SEL_W-1:0] ratio_sel_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             cmp_pulse
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cmp_q, cmp_d;

  // limit = ratio - 1, a run of (sel+1) ones
  always_comb begin
    limit = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(ratio_sel));
  end

  always_comb begin
    cnt_d = cnt_q;
    cmp_d = 1'b0;
    if (ref_tick) begin
      if (cnt_q >= limit) begin
        cnt_d = '0;
        cmp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  assign cmp_pulse = cmp_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_pulse,
  input  logic fb_tick,
  output logic up_req,
  output logic dn_req
);
  logic up_q, up_d, dn_q, dn_d;

  always_comb begin
    if (up_q && dn_q) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_q | cmp_pulse;
      dn_d = dn_q | fb_tick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_req = up_q;
  assign dn_req = dn_q;
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int LOCK_CYCLES = 16,
  parameter int MAX_WIDTH   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  input  logic dn_req,
  input  logic cmp_pulse,
  output logic locked
);
  localparam int RUN_W  = $clog2(MAX_WIDTH + 1);
  localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(MAX_WIDTH);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_CYCLES);

  logic [RUN_W-1:0]  run_q, run_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic              active, wide;

  always_comb begin
    active = up_req | dn_req;
    wide   = active && (run_q == RUN_MAX);
    if (!active)              run_d = '0;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                      run_d = run_q + 1'b1;
    good_d = good_q;
    if (wide)                                 good_d = '0;
    else if (cmp_pulse && (good_q != GOOD_MAX)) good_d = good_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      good_q <= '0;
    end else begin
      run_q  <= run_d;
      good_q <= good_d;
    end
  end

  assign locked = (good_q == GOOD_MAX);
endmodule

// File: rtl/pll_phase_ctrl.sv
module pll_phase_ctrl
  import pll_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              fb_tick,
  input  logic [SEL_W-1:0]  ratio_sel,
  input  logic              pump_disable,
  input  logic              drive_off,
  input  logic              test_mode,
  input  logic [PORT_W-1:0] port_data,
  output logic              up_req,
  output logic              dn_req,
  output logic              up_oe,
  output logic              dn_oe,
  output logic              drive_en,
  output logic              lock_out,
  output logic              lock_oe,
  output logic [PORT_W-1:0] port_out
);
  logic rst_n_s;
  logic cmp_pulse;
  logic locked;
  logic fb_half_q, fb_half_d;

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  ref_divider #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .ref_tick(ref_tick),
    .ratio_sel(ratio_sel), .cmp_pulse(cmp_pulse)
  );

  pfd_core u_pfd (
    .clk(clk), .rst_n(rst_n_s), .cmp_pulse(cmp_pulse),
    .fb_tick(fb_tick), .up_req(up_req), .dn_req(dn_req)
  );

  lock_monitor #(.LOCK_CYCLES(LOCK_CYCLES), .MAX_WIDTH(MAX_WIDTH)) u_lock (
    .clk(clk), .rst_n(rst_n_s), .up_req(up_req), .dn_req(dn_req),
    .cmp_pulse(cmp_pulse), .locked(locked)
  );

  always_comb fb_half_d = fb_half_q ^ fb_tick;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) fb_half_q <= 1'b0;
    else          fb_half_q <= fb_half_d;
  end

  always_comb begin
    up_oe    = ~pump_disable;
    dn_oe    = ~pump_disable;
    drive_en = ~drive_off;
    lock_out = 1'b0;
    lock_oe  = ~locked;
    port_out = port_data;
    if (test_mode) begin
      port_out[0] = fb_half_q;
      port_out[1] = cmp_pulse;
    end
  end
endmodule

// File: rtl/pll_phase_ctrl_chk.sv
module pll_phase_ctrl_chk (
  input logic clk,
  input logic rst_n_s,
  input logic cmp_pulse,
  input logic fb_tick,
  input logic fb_half,
  input logic up_req,
  input logic dn_req,
  input logic lock_oe
);
  AST_CMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmp_pulse |=> !cmp_pulse); // R1

  AST_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (up_req && dn_req) |=> (!up_req && !dn_req)); // R3

  AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmp_pulse && !(up_req && dn_req)) |=> up_req); // R3

  AST_DN_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fb_tick && !(up_req && dn_req)) |=> dn_req); // R3

  AST_WIDE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((up_req || dn_req) && $past(up_req || dn_req) && $past(up_req || dn_req, 2)) |=> lock_oe); // R7

  AST_FB_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    fb_tick |=> (fb_half != $past(fb_half))); // R8
endmodule

bind pll_phase_ctrl pll_phase_ctrl_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .cmp_pulse(cmp_pulse), .fb_tick(fb_tick),
  .fb_half(fb_half_q), .up_req(up_req), .dn_req(dn_req), .lock_oe(lock_oe)
);

// File: tb/tb_pll_phase_ctrl.sv
module tb_pll_phase_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, ref_tick, fb_tick, pump_disable, drive_off, test_mode;
  logic [2:0] ratio_sel;
  logic [1:0] port_data;
  logic       up_req, dn_req, up_oe, dn_oe, drive_en, lock_out, lock_oe;
  logic [1:0] port_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_phase_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .ratio_sel(ratio_sel), .pump_disable(pump_disable), .drive_off(drive_off),
    .test_mode(test_mode), .port_data(port_data), .up_req(up_req), .dn_req(dn_req),
    .up_oe(up_oe), .dn_oe(dn_oe), .drive_en(drive_en), .lock_out(lock_out),
    .lock_oe(lock_oe), .port_out(port_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 0; fb_tick = 0; pump_disable = 0; drive_off = 0;
    test_mode = 1; ratio_sel = 0; port_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    int pulses;
    do_reset();
    // R9 reset state
    check(up_req == 0 && dn_req == 0, "R9 requests", {up_req, dn_req}, 0);
    check(lock_oe == 1 && lock_out == 0, "R9 lock flag", lock_oe, 1);
    check(port_out[0] == 0, "R9 feedback toggle", port_out[0], 0);

    // R1 sweep over every ratio code
    for (int k = 0; k < 8; k++) begin
      int n;
      do_reset();
      n = 2 << k;
      ratio_sel = 3'(k);
      ref_tick = 1;
      bad = 0;
      for (int i = 1; i <= 2 * n; i++) begin
        @(negedge clk);
        if (port_out[1] != ((i % n) == 0)) bad++;
      end
      check(bad == 0, $sformatf("R1 ratio code %0d mismatched cycles", k), bad, 0);
    end

    // R2 lower the ratio while the count is high
    do_reset();
    ratio_sel = 3'd7;
    ref_tick = 1;
    repeat (10) @(negedge clk);
    check(port_out[1] == 0, "R2 no pulse before change", port_out[1], 0);
    ratio_sel = 3'd0;
    @(negedge clk);
    check(port_out[1] == 1, "R2 wrap pulse", port_out[1], 1);
    @(negedge clk);
    check(port_out[1] == 0, "R2 gap after wrap", port_out[1], 0);
    @(negedge clk);
    check(port_out[1] == 1, "R2 new period", port_out[1], 1);

    // R6 lock acquisition with aligned feedback, R3 paired clear
    do_reset();
    ratio_sel = 3'd0;
    ref_tick = 1;
    pulses = 0;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (lock_oe != (pulses < 16)) bad++;
      if (up_req != dn_req) bad++;
      if (lock_out != 0) bad++;
      if (port_out[1]) pulses++;
      fb_tick = port_out[1];
    end
    check(bad == 0, "R6 lock count sequence", bad, 0);
    check(lock_oe == 0, "R6 locked after 16 periods", lock_oe, 0);

    // R7 feedback stops: up stays high, lock drops
    fb_tick = 0;
    repeat (5) @(negedge clk);
    check(up_req == 1 && dn_req == 0, "R3 up only when feedback missing", {up_req, dn_req}, 2);
    check(lock_oe == 1, "R7 wide pulse drops lock", lock_oe, 1);

    // R4 pump disable, R5 drive off
    check(up_oe == 1 && dn_oe == 1, "R4 enables on", {up_oe, dn_oe}, 3);
    pump_disable = 1;
    #1;
    check(up_oe == 0 && dn_oe == 0, "R4 enables off", {up_oe, dn_oe}, 0);
    check(up_req == 1, "R4 request unchanged", up_req, 1);
    pump_disable = 0;
    check(drive_en == 1, "R5 drive on", drive_en, 1);
    drive_off = 1;
    #1;
    check(drive_en == 0, "R5 drive off", drive_en, 0);

    // R3 down direction, R8 feedback toggle
    do_reset();
    ref_tick = 0;
    fb_tick = 1;
    @(negedge clk);
    check(dn_req == 1 && up_req == 0, "R3 down only", {up_req, dn_req}, 1);
    check(port_out[0] == 1, "R8 toggle after one tick", port_out[0], 1);
    repeat (2) @(negedge clk);
    check(port_out[0] == 1, "R8 toggle after three ticks", port_out[0], 1);
    fb_tick = 0;

    // R8 normal mode passes data
    for (int d = 0; d < 4; d++) begin
      test_mode = 0;
      port_data = 2'(d);
      #1;
      check(port_out == 2'(d), "R8 port data", port_out, d);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule